// File: doc/BRIEF.md
# Two-Level Activity-Driven Clock Gater for a DMA Engine

This block feeds the gated clocks of a multi-channel DMA engine. It watches each channel's activity: its peripheral request lines, its outstanding bus-master work, master-side strobes and configuration writes aimed at it. When a channel has been quiet for a set number of consecutive cycles, the block stops that channel's clock. When every channel clock is stopped, it also stops the shared controller clock. The counters and the wake logic stay on the free-running clock.

Wake-up costs no cycle. Raw activity feeds the enable of each gating latch combinationally, so the clock edge at the end of the cycle in which activity appears already reaches the channel. Each gated clock comes from a latch that is open while the clock is low, followed by an AND with the clock. A bypass input forces every clock on. Per-channel and global flags report which clocks are held for the coming edge.

Top module: `dma_clkgate_ctrl`

## Requirements
- R1: Channel c counts as active in a cycle when it is enabled and shows any of these: a request on a handshake line i with i mod NUM_CH = c, a busy (outstanding transaction) flag, or a master activity strobe. It also counts as active when `slv_wr` is high with `slv_ch` = c, even while the channel is disabled. Requests, busy and strobes of a disabled channel are ignored.
- R2: After HYST consecutive inactive cycles, a channel's clock stops passing edges. It stays stopped while the channel stays inactive.
- R3: The edge at the end of the first active cycle after a stop is passed to the channel, with no added latency.
- R4: Reset clears all idle counters. While reset is held, and for the first HYST cycles after reset, every clock runs.
- R5: The global clock passes an edge whenever at least one channel clock does or bypass is high. It is stopped only when every channel clock is stopped.
- R6: While `bypass` is high, every channel clock and the global clock pass every edge, and all gated flags read 0. Bypass does not reset the idle counters.
- R7: Each gated clock is low throughout the low phase of `clk`. It rises at most once per `clk` period, together with `clk`.
- R8: `ch_gated[c]` and `glb_gated` are 1 exactly when the corresponding clock will block the coming edge.
- R9: A register clocked by a gated clock keeps its value while that clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Force all clocks on |
| ch_en | input | NUM_CH | Channel enabled |
| ch_busy | input | NUM_CH | Channel has an outstanding bus transaction |
| mst_act | input | NUM_CH | Bus master activity strobe per channel |
| hs_req | input | NUM_HS | Peripheral handshake requests; line i belongs to channel i mod NUM_CH |
| slv_wr | input | 1 | Configuration write strobe |
| slv_ch | input | CH_W | Channel targeted by the configuration write |
| ch_gclk | output | NUM_CH | Gated channel clocks |
| glb_gclk | output | 1 | Gated controller clock |
| ch_gated | output | NUM_CH | Channel clock held for the coming edge |
| glb_gated | output | 1 | Controller clock held for the coming edge |

## Verification
The bench builds the block with NUM_CH=4, NUM_HS=8 and HYST=3. With these values, two request lines share each channel, so the modulo mapping can be checked from both lines. The short window brings the gate, stay-gated and wake transitions within a few cycles of each other, so many of them occur in one run. Four channels also let a sparse random phase reach the state where every channel sleeps and the global clock stops.

// File: rtl/dma_clkgate_ctrl.sv
module dma_clkgate_ctrl #(
  parameter int NUM_CH = 8,
  parameter int NUM_HS = 16,
  parameter int HYST   = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic [NUM_CH-1:0] mst_act,
  input  logic [NUM_HS-1:0] hs_req,
  input  logic              slv_wr,
  input  logic [CH_W-1:0]   slv_ch,
  output logic [NUM_CH-1:0] ch_gclk,
  output logic              glb_gclk,
  output logic [NUM_CH-1:0] ch_gated,
  output logic              glb_gated
);
  localparam int CW = $clog2(HYST + 1);

  logic [NUM_CH-1:0] hs_any, ch_act, ch_run;
  logic              glb_run, glb_en_l;

  always_comb begin
    hs_any = '0;
    for (int i = 0; i < NUM_HS; i++)
      hs_any[i % NUM_CH] = hs_any[i % NUM_CH] | hs_req[i];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CW-1:0] idle_cnt;
    logic          en_l;

    assign ch_act[c] = (ch_en[c] & (hs_any[c] | ch_busy[c] | mst_act[c]))
                     | (slv_wr && slv_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         idle_cnt <= '0;
      else if (ch_act[c])                 idle_cnt <= '0;
      else if (idle_cnt != CW'(HYST))     idle_cnt <= idle_cnt + 1'b1;

    assign ch_run[c] = ch_act[c] | (idle_cnt != CW'(HYST));

    always_latch
      if (!clk) en_l <= ch_run[c] | bypass;

    assign ch_gclk[c]  = clk & en_l;
    assign ch_gated[c] = ~(ch_run[c] | bypass);

    // R2
    gate_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_gated[c] |-> $past(!ch_act[c]));
    // R2
    stay_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_gated[c] |=> (ch_gated[c] || ch_act[c] || bypass));
  end

  assign glb_run = (|ch_run) | bypass;

  always_latch
    if (!clk) glb_en_l <= glb_run;

  assign glb_gclk  = clk & glb_en_l;
  assign glb_gated = ~glb_run;

  // R5
  global_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_gated |-> (&ch_gated));
  // R6
  bypass_forces_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (ch_gated == '0 && !glb_gated));
endmodule

// File: tb/dma_clkgate_ctrl_bench.sv
module dma_clkgate_ctrl_bench;
  localparam int NC = 4;
  localparam int NH = 8;
  localparam int HY = 3;
  localparam int CWB = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0, bypass = 1'b0, slv_wr = 1'b0;
  logic [NC-1:0]  ch_en = '0, ch_busy = '0, mst_act = '0;
  logic [NH-1:0]  hs_req = '0;
  logic [CWB-1:0] slv_ch = '0;
  logic [NC-1:0]  ch_gclk, ch_gated;
  logic           glb_gclk, glb_gated;

  dma_clkgate_ctrl #(.NUM_CH(NC), .NUM_HS(NH), .HYST(HY)) u_dma_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .ch_en(ch_en), .ch_busy(ch_busy),
    .mst_act(mst_act), .hs_req(hs_req), .slv_wr(slv_wr), .slv_ch(slv_ch),
    .ch_gclk(ch_gclk), .glb_gclk(glb_gclk), .ch_gated(ch_gated), .glb_gated(glb_gated));

  int vec = 0, bad = 0;
  int mcnt[NC];
  int exp_edges[NC];
  int exp_gedges = 0;
  int dom_cnt[NC];
  int dom_glb;

  for (genvar g = 0; g < NC; g++) begin : g_dom
    always @(posedge ch_gclk[g] or negedge rst_n)
      if (!rst_n) dom_cnt[g] <= 0;
      else        dom_cnt[g] <= dom_cnt[g] + 1;
  end
  always @(posedge glb_gclk or negedge rst_n)
    if (!rst_n) dom_glb <= 0;
    else        dom_glb <= dom_glb + 1;

  task automatic check(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    bit a[NC];
    bit run[NC];
    bit grun;
    #1;
    grun = bypass;
    for (int c = 0; c < NC; c++) begin
      bit h = 0;
      for (int i = 0; i < NH; i++) if (hs_req[i] && (i % NC) == c) h = 1;
      a[c]   = (ch_en[c] && (h || ch_busy[c] || mst_act[c])) || (slv_wr && slv_ch == c);
      run[c] = bypass || a[c] || (mcnt[c] != HY);
      if (run[c]) grun = 1;
      check("R8 ch_gated", ch_gated[c], !run[c]);
      check("R7 low phase", ch_gclk[c], 0);
    end
    check("R8 glb_gated", glb_gated, !grun);
    check("R7 glb low phase", glb_gclk, 0);
    @(posedge clk); #2;
    for (int c = 0; c < NC; c++) begin
      check(tag, ch_gclk[c], run[c]);
      if (rst_n && run[c]) exp_edges[c]++;
      check("R9 channel domain", dom_cnt[c], exp_edges[c]);
      if (!rst_n || a[c]) mcnt[c] = 0;
      else if (mcnt[c] < HY) mcnt[c]++;
    end
    check("R5 glb clock", glb_gclk, grun);
    if (rst_n && grun) exp_gedges++;
    check("R9 glb domain", dom_glb, exp_gedges);
    @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mcnt[c] = 0; exp_edges[c] = 0; end
    @(negedge clk);
    repeat (3) cycle("R4 in reset");
    rst_n = 1'b1;
    repeat (HY) cycle("R4 window");
    repeat (4) cycle("R2 gated");
    ch_en[1] = 1'b1; hs_req[5] = 1'b1;
    repeat (2) cycle("R3 wake via line 5");
    hs_req = '0;
    repeat (5) cycle("R2 regate");
    hs_req[1] = 1'b1;
    repeat (2) cycle("R1 line 1 same channel");
    hs_req = '0; hs_req[2] = 1'b1;
    repeat (4) cycle("R1 disabled ignored");
    hs_req = '0; slv_wr = 1'b1; slv_ch = 2'd3;
    cycle("R1 slave write wakes disabled");
    slv_wr = 1'b0; ch_en[0] = 1'b1; mst_act[0] = 1'b1;
    cycle("R1 master strobe");
    mst_act = '0; ch_en[2] = 1'b1; ch_busy[2] = 1'b1;
    repeat (3) cycle("R1 busy");
    ch_busy = '0;
    repeat (6) cycle("R2 all idle");
    bypass = 1'b1;
    repeat (3) cycle("R6 bypass");
    bypass = 1'b0;
    repeat (2) cycle("R6 after bypass");
    for (int k = 0; k < 400; k++) begin
      ch_en   = NC'($urandom);
      ch_busy = NC'((($urandom % 6) == 0) ? $urandom : 0);
      mst_act = NC'((($urandom % 8) == 0) ? $urandom : 0);
      hs_req  = NH'((($urandom % 5) == 0) ? (1 << ($urandom % NH)) : 0);
      slv_wr  = (($urandom % 10) == 0);
      slv_ch  = CWB'($urandom);
      bypass  = (($urandom % 40) == 0);
      if ((k % 50) > 30) begin
        ch_busy = '0; mst_act = '0; hs_req = '0; slv_wr = 1'b0; bypass = 1'b0;
      end
      cycle("R3 mixed traffic");
    end
    report();
  end
endmodule